// File: doc/BRIEF.md
# Self-Halting Swallow Counter

This block is the swallow counter of a pulse-swallow frequency divider. A dual-modulus prescaler divides a fast clock by N+1 or by N and emits one slow event per prescaler period. The swallow counter counts those events. While its count differs from a programmed swallow value, the modulus control output stays low and the prescaler divides by N+1. When the count reaches the programmed value, modulus control goes high and the prescaler switches to N.

Once the count matches, the counter blocks its own count input and holds its state. It does not restart on its own. A clear pulse from the companion program counter marks the end of one output period. That pulse returns the count to zero and drops modulus control, ready for the next period. With the program counter set to P and the swallow value set to S (S no larger than P), each output period lasts N·P + S fast clock cycles.

The cell-level clock gating of a ripple implementation is replaced here by a one-cycle slow-event enable on a single fast clock.

Top module: `swallow_ctr`

## Requirements
- R1: A synchronous active-low reset clears the count to zero. After reset with a nonzero swallow value, mod_ctl is 0.
- R2: While mod_ctl is 0, each cycle with slow_tick high and prog_rst low adds exactly one to the count. Cycles without slow_tick leave the count unchanged.
- R3: mod_ctl is 1 exactly when all CNT_W bits of the count equal swallow_val. With swallow value S, it rises after the S-th slow event that follows a clear.
- R4: While mod_ctl is 1, slow_tick is masked and the count holds. If swallow_val is then raised by one, counting resumes from the held value.
- R5: Once asserted, mod_ctl stays high until prog_rst or rst_n. A prog_rst pulse clears the count, so mod_ctl is low in the next cycle when swallow_val is nonzero.
- R6: With swallow_val equal to 0, mod_ctl is 1 in the first cycle after any clear (prog_rst or rst_n).
- R7: If prog_rst and slow_tick are high in the same cycle, the clear wins and the count becomes 0, not 1.
- R8: Paired with a prescaler that divides by N+1 while mod_ctl is 0 and by N while it is 1, and with a program counter that counts P slow events and then pulses prog_rst, each output period is N·P + S fast cycles for 0 ≤ S ≤ P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-cycle pulse per prescaler output period |
| prog_rst | input | 1 | Synchronous clear from the program counter |
| swallow_val | input | CNT_W | Programmed swallow value S |
| mod_ctl | output | 1 | Modulus control: 0 selects N+1, 1 selects N |

## Verification
The hardest state to reach from the ports is the frozen state, because the count itself is not visible. The stimulus sends extra slow events after the match, then raises swallow_val by one. A correct counter re-arms and matches after a single further event. A counter that kept counting would have run past the new target.

Clear-versus-event priority is reached by pulsing prog_rst and slow_tick in the same cycle. The frame length is checked by closing the loop with a behavioural prescaler and program counter. This covers the directed settings P = 96 and S = 24 as well as seeded random values of N, P and S, including S = 0 and S = P.

// File: rtl/swl_pkg.sv
// Package: shared constants for the swallow counter.
// Assumes: nothing beyond standard SystemVerilog.
package swl_pkg;
    // Default width of the swallow count and programmed value.
    localparam int unsigned SWL_CNT_W = 6;
endpackage

// File: rtl/swl_match.sv
// Module: swl_match
// Compares the running count with the programmed value one bit at a time,
// then reduces the per-bit equality flags into a single all-equal flag.
// Assumes: purely combinational; both operands are W bits wide.
module swl_match #(
    parameter int unsigned W = swl_pkg::SWL_CNT_W
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] bit_eq;

    // One equality cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_eq[i] = ~(cnt[i] ^ target[i]);
    end

    // All-equal detector.
    assign hit = &bit_eq;
endmodule

// File: rtl/swl_count_reg.sv
// Module: swl_count_reg
// Holds the swallow count. Each event is ANDed with the inverse of the halt
// flag, so the count freezes while halted. A clear has priority over an event.
// Assumes: synchronous active-low reset; clr and step_en are one-cycle pulses
// synchronous to clk.
module swl_count_reg #(
    parameter int unsigned W = swl_pkg::SWL_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         clr,
    input  logic         halt,
    output logic [W-1:0] cnt
);
    logic adv;

    // Masked count input: no advance while halted.
    assign adv = step_en & ~halt;

    // Count register: reset, then clear, then masked increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    // R2: an unmasked event advances the count by one.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !halt && !clr) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R2: with no event and no clear, the count holds.
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !clr) |=> $stable(cnt));

    // R4: while halted, the count is frozen.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt));

    // R5: a clear empties the count.
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R7: a clear beats a simultaneous event.
    assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && step_en) |=> (cnt == '0));
endmodule

// File: rtl/swallow_ctr.sv
// Module: swallow_ctr
// Swallow counter of a pulse-swallow divider. It counts slow events and
// raises mod_ctl when the count equals swallow_val, then freezes until
// prog_rst arrives from the program counter.
// Assumes: swallow_val is stable within an output period; slow_tick and
// prog_rst are single-cycle pulses on clk.
module swallow_ctr #(
    parameter int unsigned CNT_W = swl_pkg::SWL_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             prog_rst,
    input  logic [CNT_W-1:0] swallow_val,
    output logic             mod_ctl
);
    logic [CNT_W-1:0] count_q;
    logic             match;

    // Count storage with self-masking input.
    swl_count_reg #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (slow_tick),
        .clr     (prog_rst),
        .halt    (match),
        .cnt     (count_q)
    );

    // Per-bit compare with the programmed value.
    swl_match #(.W(CNT_W)) u_match (
        .cnt    (count_q),
        .target (swallow_val),
        .hit    (match)
    );

    // Modulus control follows the match flag.
    assign mod_ctl = match;

    // R6: after a clear, mod_ctl reflects whether the swallow value is zero.
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_rst |=> (mod_ctl == (swallow_val == '0)));

    // R5: with a steady target, mod_ctl only falls through a clear.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ctl && !prog_rst) |=> (mod_ctl || !$stable(swallow_val)));
endmodule

// File: tb/swallow_ctr_tb.sv
module swallow_ctr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         slow_tick = 1'b0;
    logic         prog_rst = 1'b0;
    logic [W-1:0] swallow_val = '0;
    logic         mod_ctl;

    int checks = 0;
    int failures = 0;
    int cyc_total = 0;
    bit finished = 0;

    swallow_ctr #(.CNT_W(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick   (slow_tick),
        .prog_rst    (prog_rst),
        .swallow_val (swallow_val),
        .mod_ctl     (mod_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int frame_len(input int n, input int p, input int s);
        return n * p + s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the edge.
    task automatic step(input logic t, input logic r);
        @(negedge clk);
        slow_tick = t;
        prog_rst  = r;
        @(posedge clk);
        #1;
        slow_tick = 1'b0;
        prog_rst  = 1'b0;
    endtask

    // Closed loop with a behavioural prescaler and program counter.
    task automatic run_loop(input int n, input int p, input int s, input int frames);
        int pcnt = 0;
        int pc = 0;
        int cyc = 0;
        int done_frames = 0;
        swallow_val = W'(s);
        step(1'b0, 1'b1);
        while (done_frames < frames) begin
            int  lim;
            logic t;
            logic r;
            @(negedge clk);
            check("R3 loop", int'(mod_ctl), int'(pc >= s));
            lim = mod_ctl ? n : n + 1;
            t = (pcnt == lim - 1);
            r = t && (pc == p - 1);
            slow_tick = t;
            prog_rst  = r;
            pcnt = t ? 0 : pcnt + 1;
            pc   = r ? 0 : (t ? pc + 1 : pc);
            cyc++;
            if (r) begin
                check("R8 frame", cyc, frame_len(n, p, s));
                cyc = 0;
                done_frames++;
            end
        end
        @(negedge clk);
        slow_tick = 1'b0;
        prog_rst  = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        swallow_val = 6'd5;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 check("R1 reset", int'(mod_ctl), 0);

        // R2 / R3: match after exactly five events.
        for (int k = 1; k <= 5; k++) begin
            step(1'b1, 1'b0);
            check("R2 count", int'(mod_ctl), int'(k >= 5));
        end
        step(1'b0, 1'b0);
        check("R2 idle", int'(mod_ctl), 1);

        // R4: frozen count re-arms after raising the target by one.
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0);
            check("R4 masked", int'(mod_ctl), 1);
        end
        swallow_val = 6'd6;
        #1 check("R4 rearm", int'(mod_ctl), 0);
        step(1'b1, 1'b0);
        check("R4 resume", int'(mod_ctl), 1);

        // R5: sticky until clear.
        repeat (4) step(1'b0, 1'b0);
        check("R5 sticky", int'(mod_ctl), 1);
        step(1'b0, 1'b1);
        check("R5 clear", int'(mod_ctl), 0);

        // R6: zero swallow value.
        swallow_val = 6'd0;
        step(1'b0, 1'b1);
        check("R6 clear", int'(mod_ctl), 1);
        step(1'b1, 1'b0);
        check("R6 masked", int'(mod_ctl), 1);
        rst_n = 1'b0;
        step(1'b0, 1'b0);
        rst_n = 1'b1;
        check("R6 reset", int'(mod_ctl), 1);

        // R7: clear wins over a simultaneous event.
        swallow_val = 6'd2;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R7 prio", int'(mod_ctl), 0);
        step(1'b1, 1'b0);
        check("R7 one", int'(mod_ctl), 0);
        step(1'b1, 1'b0);
        check("R7 two", int'(mod_ctl), 1);

        // R8: directed settings, then corner and random settings.
        run_loop(2, 96, 24, 2);
        run_loop(4, 96, 24, 1);
        run_loop(2, 1, 0, 2);
        run_loop(2, 1, 1, 2);
        run_loop(8, 5, 5, 2);
        run_loop(16, 63, 63, 1);
        for (int k = 0; k < 12; k++) begin
            int n = 2 << ($urandom % 4);
            int p = 1 + ($urandom % 40);
            int s = $urandom % (p + 1);
            run_loop(n, p, s, 2);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 190000 && !finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule